// File: doc/BRIEF.md
# Smart Card Activation Sequencer

This block sits between a host controller and the power, clock, reset and I/O switches of one contact smart card slot. It brings the card up and takes it down in a fixed order. A falling edge on the active-low session command powers the card, then opens the I/O line, then starts the card clock, and then hands the card reset line to the host. Raising the command again, or any fault during a session, runs the reverse order. That order is: reset low, clock stopped, I/O closed, supply off. Each step lasts a programmable number of clock cycles.

A single active-low interrupt line serves two purposes. While the session command is high it shows whether a card is in the slot. While the command is low it reports a latched fault. The fault is latched when any of four conditions occurs during activation or an active session: the card is pulled out, the logic supply drops, the card supply fails, or the card draws too much current. Each of these also starts deactivation on its own. The card voltage (3V or 5V) is captured once per session.

Top module: `sc_act_seq`

## Requirements
- R1: While reset is applied, and until the first host action after it, vcc_en, io_en, clk_en, card_rst and vcc_sel_5v are 0 and irq_n is 1.
- R2: From idle, a high-to-low transition of act_cmd_n, seen at two consecutive rising clock edges, sets vcc_en at the second of those edges.
- R3: Activation order. io_en goes to 1 exactly STEP_CYCLES cycles after vcc_en, and clk_en exactly STEP_CYCLES cycles after io_en. The session becomes live STEP_CYCLES cycles after clk_en.
- R4: card_rst stays 0 until the session is live. From then on it copies host_rst with one cycle of delay.
- R5: vcc_sel_5v takes the value of sel_5v (1 = 5V, 0 = 3V) at the edge that starts activation. Changes to sel_5v during the session do not alter it.
- R6: If act_cmd_n is high at an edge during activation or a live session, deactivation starts. card_rst is 0 after that edge. clk_en goes to 0 STEP_CYCLES cycles later, io_en 2·STEP_CYCLES cycles later and vcc_en 3·STEP_CYCLES cycles later. The block is idle after 4·STEP_CYCLES cycles. A signal that was never raised stays 0.
- R7: Any of card_present = 0, vdd_low = 1, vcc_fault = 1 or over_cur = 1 at an edge during activation or a live session starts the same deactivation as R6, even if the condition lasts a single cycle.
- R8: irq_n is registered with one cycle of delay. When act_cmd_n is high it equals card_present. When act_cmd_n is low it is 0 if a fault (R7) has been latched in this session and 1 otherwise. Only a high act_cmd_n clears the latch.
- R9: Activation starts only from idle on a fresh falling edge. A falling edge during deactivation, and a command held low after a fault, do not start a new session.
- R10: A falling edge of act_cmd_n while vdd_low = 1 does not start activation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| act_cmd_n | input | 1 | Host session command, active low |
| host_rst | input | 1 | Host value for the card reset line |
| sel_5v | input | 1 | Card voltage request, 1 = 5V, 0 = 3V |
| card_present | input | 1 | Card presence switch, 1 = card inserted |
| vdd_low | input | 1 | Logic supply supervisor fault |
| vcc_fault | input | 1 | Card supply voltage fault |
| over_cur | input | 1 | Card supply overcurrent |
| vcc_en | output | 1 | Card supply enable |
| vcc_sel_5v | output | 1 | Card supply voltage select, 1 = 5V |
| io_en | output | 1 | Card I/O line enable |
| clk_en | output | 1 | Card clock gate |
| card_rst | output | 1 | Card reset line |
| irq_n | output | 1 | Host interrupt, active low |

## Verification
Some rules hold on every cycle, and the assertions check them there. The switches nest: the clock only runs with I/O enabled, I/O only with supply on, and card reset only with the clock running. The supply only rises after a low command with no supervisor fault. The voltage select stays fixed while the supply is on. card_rst is 0 one cycle after a high command or a card-side fault. The interrupt follows presence whenever the command is high. The exact step spacing, the latched fault and when it clears, and the ignoring of late edges are shown by the bench's scenarios. So are restarts that do not happen. There, a cycle-level model runs under directed cases and long random command and fault traffic.

// File: rtl/sc_seq_pkg.sv
package sc_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_UP_PWR = 4'd1,
    ST_UP_IO  = 4'd2,
    ST_UP_CLK = 4'd3,
    ST_LIVE   = 4'd4,
    ST_DN_RST = 4'd5,
    ST_DN_CLK = 4'd6,
    ST_DN_IO  = 4'd7,
    ST_DN_PWR = 4'd8
  } seq_state_e;

  // Activation steps and the live state count as a session for fault capture.
  function automatic logic seq_in_session(input seq_state_e s);
    return (s == ST_UP_PWR) || (s == ST_UP_IO) || (s == ST_UP_CLK) || (s == ST_LIVE);
  endfunction

endpackage

// File: rtl/sc_reset_sync.sv
module sc_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic ff1_q, ff2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff1_q <= 1'b0;
      ff2_q <= 1'b0;
    end else begin
      ff1_q <= 1'b1;
      ff2_q <= ff1_q;
    end
  end

  assign rst_sync_n = ff2_q;

endmodule

// File: rtl/sc_step_timer.sv
module sc_step_timer #(
  parameter int unsigned STEP_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic done
);

  localparam int unsigned CW = $clog2(STEP_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(STEP_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (restart) begin
      cnt_d = LOAD;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sc_host_status.sv
module sc_host_status (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_n,
  input  logic present,
  input  logic fault_hit,
  output logic irq_n
);

  logic fault_q, fault_d;
  logic irq_q, irq_d;

  always_comb begin
    // A high command clears the latch; otherwise a fault in session sets it.
    fault_d = cmd_n ? 1'b0 : (fault_q | fault_hit);
    irq_d   = cmd_n ? present : ~fault_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      irq_q   <= 1'b1;
    end else begin
      fault_q <= fault_d;
      irq_q   <= irq_d;
    end
  end

  assign irq_n = irq_q;

endmodule

// File: rtl/sc_act_seq.sv
module sc_act_seq #(
  parameter int unsigned STEP_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_cmd_n,
  input  logic host_rst,
  input  logic sel_5v,
  input  logic card_present,
  input  logic vdd_low,
  input  logic vcc_fault,
  input  logic over_cur,
  output logic vcc_en,
  output logic vcc_sel_5v,
  output logic io_en,
  output logic clk_en,
  output logic card_rst,
  output logic irq_n
);
  import sc_seq_pkg::*;

  seq_state_e state_q, state_d;
  logic rst_s_n;
  logic step_done, step_restart;
  logic fault_cond, abort, in_sess, cmd_fall, fault_hit;
  logic cmd_prev_q;
  logic vcc_q, vcc_d, io_q, io_d, clk_q, clk_d, rst_q, rst_d, vsel_q, vsel_d;

  sc_reset_sync u_rsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  sc_step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .restart (step_restart),
    .done    (step_done)
  );

  assign fault_cond = ~card_present | vdd_low | vcc_fault | over_cur;
  assign abort      = act_cmd_n | fault_cond;
  assign in_sess    = seq_in_session(state_q);
  assign fault_hit  = in_sess & fault_cond;
  assign cmd_fall   = cmd_prev_q & ~act_cmd_n;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (cmd_fall && !vdd_low) state_d = ST_UP_PWR;
      ST_UP_PWR: if (abort) state_d = ST_DN_RST; else if (step_done) state_d = ST_UP_IO;
      ST_UP_IO:  if (abort) state_d = ST_DN_RST; else if (step_done) state_d = ST_UP_CLK;
      ST_UP_CLK: if (abort) state_d = ST_DN_RST; else if (step_done) state_d = ST_LIVE;
      ST_LIVE:   if (abort) state_d = ST_DN_RST;
      ST_DN_RST: if (step_done) state_d = ST_DN_CLK;
      ST_DN_CLK: if (step_done) state_d = ST_DN_IO;
      ST_DN_IO:  if (step_done) state_d = ST_DN_PWR;
      ST_DN_PWR: if (step_done) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign step_restart = (state_d != state_q);

  // Output step actions: activation steps only set, deactivation steps only clear.
  always_comb begin
    vcc_d  = vcc_q;
    io_d   = io_q;
    clk_d  = clk_q;
    vsel_d = vsel_q;
    if (step_restart) begin
      unique case (state_d)
        ST_UP_PWR: begin vcc_d = 1'b1; vsel_d = sel_5v; end
        ST_UP_IO:  io_d  = 1'b1;
        ST_UP_CLK: clk_d = 1'b1;
        ST_DN_CLK: clk_d = 1'b0;
        ST_DN_IO:  io_d  = 1'b0;
        ST_DN_PWR: vcc_d = 1'b0;
        default: ;
      endcase
    end
    rst_d = (state_d == ST_LIVE) & host_rst;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q    <= ST_IDLE;
      cmd_prev_q <= 1'b0;
      vcc_q      <= 1'b0;
      io_q       <= 1'b0;
      clk_q      <= 1'b0;
      rst_q      <= 1'b0;
      vsel_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      cmd_prev_q <= act_cmd_n;
      vcc_q      <= vcc_d;
      io_q       <= io_d;
      clk_q      <= clk_d;
      rst_q      <= rst_d;
      vsel_q     <= vsel_d;
    end
  end

  sc_host_status u_status (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .cmd_n     (act_cmd_n),
    .present   (card_present),
    .fault_hit (fault_hit),
    .irq_n     (irq_n)
  );

  assign vcc_en     = vcc_q;
  assign io_en      = io_q;
  assign clk_en     = clk_q;
  assign card_rst   = rst_q;
  assign vcc_sel_5v = vsel_q;

endmodule

// File: rtl/sc_act_seq_checker.sv
module sc_act_seq_checker (
  input logic clk,
  input logic rst_n,
  input logic act_cmd_n,
  input logic card_present,
  input logic vdd_low,
  input logic vcc_fault,
  input logic over_cur,
  input logic vcc_en,
  input logic vcc_sel_5v,
  input logic io_en,
  input logic clk_en,
  input logic card_rst,
  input logic irq_n
);

  logic [1:0] age_q;
  logic       ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= 2'd0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end
  assign ready = (age_q == 2'd3);

  p_clk_needs_io_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |-> io_en);

  p_io_needs_vcc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    io_en |-> vcc_en);

  p_rst_needs_clk_r4: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst |-> clk_en);

  p_vsel_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vcc_en && $past(vcc_en)) |-> $stable(vcc_sel_5v));

  p_cmd_high_drops_rst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    act_cmd_n |=> !card_rst);

  p_fault_drops_rst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (over_cur || vcc_fault || !card_present) |=> !card_rst);

  p_irq_presence_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && act_cmd_n) |=> (irq_n == $past(card_present)));

  p_vcc_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vcc_en) |-> $past(!act_cmd_n && !vdd_low));

endmodule

bind sc_act_seq sc_act_seq_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .act_cmd_n    (act_cmd_n),
  .card_present (card_present),
  .vdd_low      (vdd_low),
  .vcc_fault    (vcc_fault),
  .over_cur     (over_cur),
  .vcc_en       (vcc_en),
  .vcc_sel_5v   (vcc_sel_5v),
  .io_en        (io_en),
  .clk_en       (clk_en),
  .card_rst     (card_rst),
  .irq_n        (irq_n)
);

// File: tb/sc_act_seq_bench.sv
`timescale 1ns/1ps
module sc_act_seq_bench;
  localparam int S = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic act_cmd_n = 1'b1, host_rst = 1'b0, sel_5v = 1'b0, card_present = 1'b1;
  logic vdd_low = 1'b0, vcc_fault = 1'b0, over_cur = 1'b0;
  logic vcc_en, vcc_sel_5v, io_en, clk_en, card_rst, irq_n;

  int checks = 0;
  int errors = 0;
  bit cmp_en = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sc_act_seq #(.STEP_CYCLES(S)) u_sc_act_seq (
    .clk(clk), .rst_n(rst_n), .act_cmd_n(act_cmd_n), .host_rst(host_rst),
    .sel_5v(sel_5v), .card_present(card_present), .vdd_low(vdd_low),
    .vcc_fault(vcc_fault), .over_cur(over_cur), .vcc_en(vcc_en),
    .vcc_sel_5v(vcc_sel_5v), .io_en(io_en), .clk_en(clk_en),
    .card_rst(card_rst), .irq_n(irq_n)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Cycle-level reference model built from the requirements.
  int   m_ph, m_age;
  logic m_vcc, m_io, m_clk, m_rst, m_vsel, m_fault, m_irq, m_prev, mr1, mr2;

  function automatic void model_reset();
    m_ph = 0; m_age = 0;
    m_vcc = 0; m_io = 0; m_clk = 0; m_rst = 0; m_vsel = 0;
    m_fault = 0; m_irq = 1; m_prev = 0;
  endfunction

  function automatic void model_step();
    logic fc;
    bit   sess;
    int   np;
    fc   = !card_present || vdd_low || vcc_fault || over_cur;
    sess = (m_ph >= 1) && (m_ph <= 4);
    np   = m_ph;
    if (m_ph == 0) begin
      if (m_prev && !act_cmd_n && !vdd_low) np = 1;          // R2, R9, R10
    end else if (sess) begin
      if (act_cmd_n || fc) np = 5;                            // R6, R7
      else if (m_ph < 4 && m_age == S - 1) np = m_ph + 1;     // R3
    end else if (m_age == S - 1) begin
      np = (m_ph == 8) ? 0 : m_ph + 1;
    end
    m_fault = act_cmd_n ? 1'b0 : (m_fault | (sess && fc));   // R8
    m_irq   = act_cmd_n ? card_present : !m_fault;
    if (np != m_ph) begin
      case (np)
        1: begin m_vcc = 1; m_vsel = sel_5v; end              // R5
        2: m_io  = 1;
        3: m_clk = 1;
        6: m_clk = 0;
        7: m_io  = 0;
        8: m_vcc = 0;
        default: ;
      endcase
      m_age = 0;
    end else begin
      m_age++;
    end
    m_rst  = (np == 4) ? host_rst : 1'b0;                     // R4
    m_prev = act_cmd_n;
    m_ph   = np;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr1 = 0; mr2 = 0; model_reset();
    end else begin
      if (!mr2) model_reset(); else model_step();
      mr2 = mr1; mr1 = 1;
    end
  end

  always @(negedge clk) begin
    if (cmp_en && !finished) begin
      chk("R3 vcc_en vs model", vcc_en, m_vcc);
      chk("R3 io_en vs model", io_en, m_io);
      chk("R6 clk_en vs model", clk_en, m_clk);
      chk("R4 card_rst vs model", card_rst, m_rst);
      chk("R5 vcc_sel_5v vs model", vcc_sel_5v, m_vsel);
      chk("R8 irq_n vs model", irq_n, m_irq);
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    tick(3);
    cmp_en = 1'b1;
    // R1 reset state
    chk("R1 vcc_en", vcc_en, 1'b0);
    chk("R1 io_en", io_en, 1'b0);
    chk("R1 clk_en", clk_en, 1'b0);
    chk("R1 card_rst", card_rst, 1'b0);
    chk("R1 irq_n", irq_n, 1'b1);
    rst_n = 1'b1;
    tick(4);
    chk("R1 idle after release", vcc_en, 1'b0);

    // R2 R3 R4 R5 activation
    sel_5v = 1'b1; host_rst = 1'b1; act_cmd_n = 1'b0;
    tick(1);
    chk("R2 vcc_en after fall", vcc_en, 1'b1);
    chk("R3 io_en still off", io_en, 1'b0);
    tick(S);
    chk("R3 io_en on", io_en, 1'b1);
    chk("R3 clk_en still off", clk_en, 1'b0);
    tick(S);
    chk("R3 clk_en on", clk_en, 1'b1);
    chk("R4 card_rst held low", card_rst, 1'b0);
    tick(S);
    chk("R4 card_rst follows host", card_rst, 1'b1);
    sel_5v = 1'b0; host_rst = 1'b0;
    tick(1);
    chk("R4 card_rst follows host low", card_rst, 1'b0);
    chk("R5 select captured", vcc_sel_5v, 1'b1);
    tick(5);
    chk("R5 select change ignored", vcc_sel_5v, 1'b1);

    // R6 normal deactivation
    act_cmd_n = 1'b1;
    tick(1);
    chk("R6 card_rst low first", card_rst, 1'b0);
    chk("R6 clk_en still on", clk_en, 1'b1);
    tick(S);
    chk("R6 clk_en off", clk_en, 1'b0);
    chk("R6 io_en still on", io_en, 1'b1);
    tick(S);
    chk("R6 io_en off", io_en, 1'b0);
    chk("R6 vcc_en still on", vcc_en, 1'b1);
    tick(S);
    chk("R6 vcc_en off", vcc_en, 1'b0);
    tick(S);
    chk("R8 irq_n shows presence", irq_n, 1'b1);

    // R10 supervisor fault blocks start
    vdd_low = 1'b1; act_cmd_n = 1'b0;
    tick(3);
    chk("R10 no start under vdd_low", vcc_en, 1'b0);
    act_cmd_n = 1'b1; vdd_low = 1'b0;
    tick(2);

    // R7 R8 R9 fault in live session
    act_cmd_n = 1'b0;
    tick(3 * S + 2);
    over_cur = 1'b1;
    tick(1);
    over_cur = 1'b0;
    chk("R7 fault drops card_rst", card_rst, 1'b0);
    chk("R8 irq_n low on fault", irq_n, 1'b0);
    tick(4 * S);
    chk("R7 fault deactivation done", vcc_en, 1'b0);
    chk("R8 fault stays latched", irq_n, 1'b0);
    tick(S);
    chk("R9 no restart while held low", vcc_en, 1'b0);
    act_cmd_n = 1'b1;
    tick(1);
    chk("R8 release clears fault", irq_n, 1'b1);
    tick(2);

    // R9 fall during deactivation ignored
    act_cmd_n = 1'b0;
    tick(3 * S + 2);
    act_cmd_n = 1'b1;
    tick(2);
    act_cmd_n = 1'b0;
    tick(4 * S + 2);
    chk("R9 late fall ignored vcc", vcc_en, 1'b0);
    chk("R9 late fall ignored io", io_en, 1'b0);
    act_cmd_n = 1'b1;
    tick(2);

    // R7 card removal during first step
    act_cmd_n = 1'b0;
    tick(2);
    card_present = 1'b0;
    tick(1);
    card_present = 1'b1;
    tick(S);
    chk("R7 removal stops io_en", io_en, 1'b0);
    chk("R8 removal latched", irq_n, 1'b0);
    tick(4 * S);
    act_cmd_n = 1'b1;
    tick(2);

    // Random traffic checked against the model
    for (int i = 0; i < 20000; i++) begin
      if ($urandom_range(0, 39) == 0) act_cmd_n = ~act_cmd_n;
      if ($urandom_range(0, 7) == 0)  host_rst = ~host_rst;
      if ($urandom_range(0, 15) == 0) sel_5v = ~sel_5v;
      if (card_present) begin
        if ($urandom_range(0, 299) == 0) card_present = 1'b0;
      end else if ($urandom_range(0, 9) == 0) card_present = 1'b1;
      if (vdd_low) begin
        if ($urandom_range(0, 4) == 0) vdd_low = 1'b0;
      end else if ($urandom_range(0, 499) == 0) vdd_low = 1'b1;
      if (vcc_fault) begin
        if ($urandom_range(0, 4) == 0) vcc_fault = 1'b0;
      end else if ($urandom_range(0, 499) == 0) vcc_fault = 1'b1;
      if (over_cur) begin
        if ($urandom_range(0, 4) == 0) over_cur = 1'b0;
      end else if ($urandom_range(0, 499) == 0) over_cur = 1'b1;
      tick(1);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule